// File: doc/BRIEF.md
# Multi-Mode 16-Bit Waveform Timer Counter

This block is the counting heart of a 16-bit timer. A 4-bit mode input picks one of sixteen counting schemes. Each scheme fixes four things: where the TOP value comes from, whether the count runs on one slope or two, when writes to the compare registers reach the comparators, and on which event the overflow strobe fires. The count advances only in cycles where the enable tick is high. Any prescaler that produces that tick sits outside the block.

Three register write ports are shared with one data bus: counter load, compare A and compare B (double-buffered), and the capture register, which is used here only as a TOP source. The block gives out the count, the direction, the compare values in force, and single-cycle strobes for TOP, BOTTOM, overflow and both compare matches. Waveform output units use these strobes and are not part of this block. The strobes are combinational. They decode the current count during a counting tick, meaning a cycle with `tick` high and no counter load.

Top module: `mm_timer16`

## Requirements
- R1: Synchronous active-high reset clears the count, both compare buffers, the compare values in force and the capture register, and sets the direction to up (`down`=0). With `tick` low, every strobe is 0.
- R2: The count changes only on a counting tick or a counter load. With `tick` low and no load it holds.
- R3: TOP by mode: 0 and 13 use 0xFFFF. Modes 1 and 5 use 0x00FF, modes 2 and 6 use 0x01FF, and modes 3 and 7 use 0x03FF. Modes 4, 9, 11 and 15 use the compare A value in force. Modes 8, 10, 12 and 14 use the capture register.
- R4: Single-slope modes (0, 4, 5, 6, 7, 12, 13, 14, 15) count up by one per tick. The tick on which the count equals TOP sends it to 0. Reserved mode 13 behaves exactly like mode 0.
- R5: Dual-slope modes (1, 2, 3, 8, 9, 10, 11) count up to TOP and then down to 0, repeating. `down` is 1 while descending. The tick at TOP moves to TOP-1, and the tick at 0 while descending moves to 1.
- R6: Compare writes always fill a buffer. The buffer moves into the value in force at once in modes 0, 4, 12 and 13. In modes 1, 2, 3, 10 and 11 it moves on a tick at TOP. In modes 5, 6, 7, 8, 9, 14 and 15 it moves on a tick at 0.
- R7: `ovf_stb` fires on a tick with the count at 0xFFFF in modes 0, 4, 12 and 13. It fires on a tick at TOP in modes 5, 6, 7, 14 and 15, and on a tick at 0 in dual-slope modes.
- R8: `top_stb` and `bot_stb` fire during a counting tick whose count equals TOP and 0, respectively.
- R9: `cmpa_stb`/`cmpb_stb` fire during a counting tick whose count equals the compare value in force. They do not fire on the first counting tick after a counter load.
- R10: A counter load (`cnt_we`) puts `wr_data` into the count at the next edge, takes priority over `tick`, and leaves the direction unchanged.
- R11: A capture register write takes effect at the next edge with no buffering.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable |
| mode | input | 4 | Waveform mode select |
| wr_data | input | 16 | Shared write data |
| cnt_we | input | 1 | Counter load strobe |
| cmpa_we | input | 1 | Compare A write strobe |
| cmpb_we | input | 1 | Compare B write strobe |
| cap_we | input | 1 | Capture register write strobe |
| count | output | 16 | Current count |
| down | output | 1 | Counting direction, 1 = down |
| cmpa_act | output | 16 | Compare A value in force |
| cmpb_act | output | 16 | Compare B value in force |
| ovf_stb | output | 1 | Overflow strobe |
| cmpa_stb | output | 1 | Compare A match strobe |
| cmpb_stb | output | 1 | Compare B match strobe |
| top_stb | output | 1 | Count-at-TOP strobe |
| bot_stb | output | 1 | Count-at-zero strobe |

## Verification
A wrong direction bit or a wrong TOP selection shows on `count` at the next counting tick. The count then either moves the wrong way or fails to wrap at the expected value, so the bench compares the count after every tick. A compare value moved into force at the wrong time shows directly on `cmpa_act` in the cycle after the triggering tick. A stale suppression flag shows as a missing or extra match strobe on the first tick after a load.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {TOP_FIXED, TOP_CMPA, TOP_CAP} top_src_e;
    typedef enum logic [1:0] {UPD_NOW, UPD_AT_TOP, UPD_AT_BOT} upd_e;
    typedef enum logic [1:0] {OVF_AT_MAX, OVF_AT_TOP, OVF_AT_BOT} ovf_e;

    typedef struct packed {
        logic       dual;   // two-slope counting
        top_src_e   src;    // where TOP comes from
        logic [1:0] fsel;   // fixed TOP: 0 full range, 1..3 = 8..10 bits
        upd_e       upd;    // compare buffer transfer point
        ovf_e       ovf;    // overflow strobe point
    } mode_cfg_t;

    function automatic mode_cfg_t mk_cfg(logic d, top_src_e s, logic [1:0] f,
                                         upd_e u, ovf_e o);
        mode_cfg_t c;
        c.dual = d;
        c.src  = s;
        c.fsel = f;
        c.upd  = u;
        c.ovf  = o;
        return c;
    endfunction

    function automatic mode_cfg_t decode_mode(logic [MODE_W-1:0] m);
        mode_cfg_t c;
        case (m)
            4'd1, 4'd2, 4'd3: c = mk_cfg(1'b1, TOP_FIXED, m[1:0], UPD_AT_TOP, OVF_AT_BOT);
            4'd4:             c = mk_cfg(1'b0, TOP_CMPA,  2'd0,   UPD_NOW,    OVF_AT_MAX);
            4'd5, 4'd6, 4'd7: c = mk_cfg(1'b0, TOP_FIXED, m[1:0], UPD_AT_BOT, OVF_AT_TOP);
            4'd8:             c = mk_cfg(1'b1, TOP_CAP,   2'd0,   UPD_AT_BOT, OVF_AT_BOT);
            4'd9:             c = mk_cfg(1'b1, TOP_CMPA,  2'd0,   UPD_AT_BOT, OVF_AT_BOT);
            4'd10:            c = mk_cfg(1'b1, TOP_CAP,   2'd0,   UPD_AT_TOP, OVF_AT_BOT);
            4'd11:            c = mk_cfg(1'b1, TOP_CMPA,  2'd0,   UPD_AT_TOP, OVF_AT_BOT);
            4'd12:            c = mk_cfg(1'b0, TOP_CAP,   2'd0,   UPD_NOW,    OVF_AT_MAX);
            4'd14:            c = mk_cfg(1'b0, TOP_CAP,   2'd0,   UPD_AT_BOT, OVF_AT_TOP);
            4'd15:            c = mk_cfg(1'b0, TOP_CMPA,  2'd0,   UPD_AT_BOT, OVF_AT_TOP);
            default:          c = mk_cfg(1'b0, TOP_FIXED, 2'd0,   UPD_NOW,    OVF_AT_MAX);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tmr16_mode_dec.sv
module tmr16_mode_dec
    import tmr16_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output mode_cfg_t         cfg
);
    always_comb cfg = decode_mode(mode);
endmodule

// File: rtl/tmr16_cmp_slot.sv
module tmr16_cmp_slot
    import tmr16_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  upd_e          upd,
    input  logic          ev_top,
    input  logic          ev_bot,
    input  logic          we,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] act
);
    logic [CW-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= '0;
            act   <= '0;
        end else begin
            if (we) buf_q <= wdata;
            case (upd)
                UPD_NOW:    if (we)     act <= wdata;
                UPD_AT_TOP: if (ev_top) act <= buf_q;
                UPD_AT_BOT: if (ev_bot) act <= buf_q;
                default:    act <= act;
            endcase
        end
    end
endmodule

// File: rtl/tmr16_count_core.sv
module tmr16_count_core
    import tmr16_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          dual,
    input  logic [CW-1:0] top_val,
    input  logic          load_we,
    input  logic [CW-1:0] load_data,
    output logic [CW-1:0] cnt,
    output logic          dn
);
    localparam logic [CW-1:0] ONE = CW'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            dn  <= 1'b0;
        end else if (load_we) begin
            cnt <= load_data;
        end else if (tick) begin
            if (!dual) begin
                dn  <= 1'b0;
                cnt <= (cnt == top_val) ? '0 : cnt + ONE;
            end else if (!dn) begin
                if (cnt >= top_val) begin
                    dn  <= 1'b1;
                    cnt <= (cnt == '0) ? '0 : cnt - ONE;
                end else begin
                    cnt <= cnt + ONE;
                end
            end else begin
                if (cnt == '0) begin
                    dn  <= 1'b0;
                    cnt <= (top_val == '0) ? '0 : ONE;
                end else begin
                    cnt <= cnt - ONE;
                end
            end
        end
    end
endmodule

// File: rtl/mm_timer16.sv
module mm_timer16
    import tmr16_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [MODE_W-1:0] mode,
    input  logic [CW-1:0]     wr_data,
    input  logic              cnt_we,
    input  logic              cmpa_we,
    input  logic              cmpb_we,
    input  logic              cap_we,
    output logic [CW-1:0]     count,
    output logic              down,
    output logic [CW-1:0]     cmpa_act,
    output logic [CW-1:0]     cmpb_act,
    output logic              ovf_stb,
    output logic              cmpa_stb,
    output logic              cmpb_stb,
    output logic              top_stb,
    output logic              bot_stb
);
    localparam int NCMP = 2;

    mode_cfg_t     cfg;
    logic [CW-1:0] cap_q;
    logic [CW-1:0] top_val;
    logic [CW-1:0] fixed_top;
    logic          cnt_tick;
    logic          ev_top;
    logic          ev_bot;
    logic          blk_q;
    logic [NCMP-1:0] cmp_we;
    logic [NCMP-1:0] cmp_hit;
    logic [CW-1:0]   cmp_act [NCMP];

    tmr16_mode_dec u_dec (.mode(mode), .cfg(cfg));

    always_ff @(posedge clk) begin
        if (rst)         cap_q <= '0;
        else if (cap_we) cap_q <= wr_data;
    end

    always_comb begin
        if (cfg.fsel == 2'd0) fixed_top = '1;
        else fixed_top = CW'((32'd1 << (32'd7 + 32'(cfg.fsel))) - 32'd1);
        case (cfg.src)
            TOP_CMPA: top_val = cmp_act[0];
            TOP_CAP:  top_val = cap_q;
            default:  top_val = fixed_top;
        endcase
    end

    assign cnt_tick = tick && !cnt_we;
    assign ev_top   = cnt_tick && (count == top_val);
    assign ev_bot   = cnt_tick && (count == '0);

    tmr16_count_core #(.CW(CW)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .dual(cfg.dual),
        .top_val(top_val), .load_we(cnt_we), .load_data(wr_data),
        .cnt(count), .dn(down)
    );

    // match suppression after a counter load
    always_ff @(posedge clk) begin
        if (rst)           blk_q <= 1'b0;
        else if (cnt_we)   blk_q <= 1'b1;
        else if (cnt_tick) blk_q <= 1'b0;
    end

    assign cmp_we = {cmpb_we, cmpa_we};

    for (genvar g = 0; g < NCMP; g++) begin : g_cmp
        tmr16_cmp_slot #(.CW(CW)) u_slot (
            .clk(clk), .rst(rst), .upd(cfg.upd), .ev_top(ev_top),
            .ev_bot(ev_bot), .we(cmp_we[g]), .wdata(wr_data),
            .act(cmp_act[g])
        );
        assign cmp_hit[g] = cnt_tick && !blk_q && (count == cmp_act[g]);
    end

    assign cmpa_act = cmp_act[0];
    assign cmpb_act = cmp_act[1];
    assign cmpa_stb = cmp_hit[0];
    assign cmpb_stb = cmp_hit[1];
    assign top_stb  = ev_top;
    assign bot_stb  = ev_bot;

    always_comb begin
        case (cfg.ovf)
            OVF_AT_TOP: ovf_stb = ev_top;
            OVF_AT_BOT: ovf_stb = ev_bot;
            default:    ovf_stb = cnt_tick && (count == '1);
        endcase
    end
endmodule

// File: rtl/mm_timer16_chk.sv
module mm_timer16_chk
    import tmr16_pkg::*;
#(
    parameter int CW = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [MODE_W-1:0] mode,
    input logic [CW-1:0]     wr_data,
    input logic              cnt_we,
    input logic              cmpa_we,
    input logic [CW-1:0]     count,
    input logic [CW-1:0]     cmpa_act,
    input logic              ovf_stb,
    input logic              top_stb
);
    mode_cfg_t cfg_c;
    logic      single_m;
    logic      imm_m;
    always_comb begin
        cfg_c    = decode_mode(mode);
        single_m = !cfg_c.dual;
        imm_m    = (mode == 4'd0) || (mode == 4'd4) || (mode == 4'd12) || (mode == 4'd13);
    end

    // R2
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_we) |=> $stable(count));

    // R10
    count_load_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> (count == $past(wr_data)));

    // R4
    single_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_we && top_stb && single_m) |=> (count == '0));

    // R7
    ovf_max_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_stb && mode == 4'd0) |-> (count == '1));

    // R6
    cmp_now_chk: assert property (@(posedge clk) disable iff (rst)
        (cmpa_we && imm_m) |=> (cmpa_act == $past(wr_data)));
endmodule

bind mm_timer16 mm_timer16_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr_data(wr_data),
    .cnt_we(cnt_we), .cmpa_we(cmpa_we), .count(count), .cmpa_act(cmpa_act),
    .ovf_stb(ovf_stb), .top_stb(top_stb)
);

// File: tb/mm_timer16_tb.sv
module mm_timer16_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [15:0] wr_data = '0;
    logic        cnt_we = 1'b0, cmpa_we = 1'b0, cmpb_we = 1'b0, cap_we = 1'b0;
    logic [15:0] count, cmpa_act, cmpb_act;
    logic        down, ovf_stb, cmpa_stb, cmpb_stb, top_stb, bot_stb;
    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_timer16 u_dut (
        .clk(clk), .rst(rst), .tick(tick), .mode(mode), .wr_data(wr_data),
        .cnt_we(cnt_we), .cmpa_we(cmpa_we), .cmpb_we(cmpb_we), .cap_we(cap_we),
        .count(count), .down(down), .cmpa_act(cmpa_act), .cmpb_act(cmpb_act),
        .ovf_stb(ovf_stb), .cmpa_stb(cmpa_stb), .cmpb_stb(cmpb_stb),
        .top_stb(top_stb), .bot_stb(bot_stb)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock edge, return at the following negedge with strobes cleared
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        tick = 0; cnt_we = 0; cmpa_we = 0; cmpb_we = 0; cap_we = 0;
    endtask

    task automatic do_reset();
        rst = 1; step(); step(); rst = 0;
    endtask

    task automatic load_cnt(logic [15:0] v);
        cnt_we = 1; wr_data = v; step();
    endtask

    task automatic tick_once();
        tick = 1; step();
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 count", count, 16'h0);
        chk("R1 cmpa_act", cmpa_act, 16'h0);
        chk("R1 down", {15'b0, down}, 16'h0);
        chk("R1 strobes", {11'b0, ovf_stb, cmpa_stb, cmpb_stb, top_stb, bot_stb}, 16'h0);
    endtask

    task automatic t_hold();
        do_reset(); mode = 4'd0;
        load_cnt(16'h1234);
        chk("R10 load", count, 16'h1234);
        step(); step(); step();
        chk("R2 hold", count, 16'h1234);
        tick_once();
        chk("R2 advance", count, 16'h1235);
    endtask

    task automatic t_normal();
        do_reset(); mode = 4'd0;
        load_cnt(16'hFFFE);
        tick = 1; #1;
        chk("R7 no ovf at FFFE", {15'b0, ovf_stb}, 16'h0);
        step();
        chk("R4 FFFF", count, 16'hFFFF);
        tick = 1; #1;
        chk("R7 ovf at max", {15'b0, ovf_stb}, 16'h1);
        chk("R8 top at FFFF", {15'b0, top_stb}, 16'h1);
        step();
        chk("R4 wrap", count, 16'h0);
    endtask

    task automatic t_ctc();
        do_reset(); mode = 4'd4;
        cmpa_we = 1; wr_data = 16'd5; step();
        chk("R6 immediate A", cmpa_act, 16'd5);
        cmpb_we = 1; wr_data = 16'd3; step();
        chk("R6 immediate B", cmpb_act, 16'd3);
        for (int i = 0; i < 5; i++) begin
            tick = 1; #1;
            if (i == 3) chk("R9 match B", {15'b0, cmpb_stb}, 16'h1);
            step();
            chk("R3 ctc count", count, 16'(i + 1));
        end
        tick = 1; #1;
        chk("R9 match A", {15'b0, cmpa_stb}, 16'h1);
        chk("R8 top ctc", {15'b0, top_stb}, 16'h1);
        chk("R7 no ovf ctc top", {15'b0, ovf_stb}, 16'h0);
        step();
        chk("R3 ctc wrap", count, 16'h0);
    endtask

    task automatic t_fast();
        do_reset(); mode = 4'd5;
        cmpa_we = 1; wr_data = 16'h40; step();
        chk("R6 buffered at bottom", cmpa_act, 16'h0);
        load_cnt(16'h00FE);
        tick_once();
        chk("R3 fast FF", count, 16'h00FF);
        tick = 1; #1;
        chk("R7 ovf at top", {15'b0, ovf_stb}, 16'h1);
        step();
        chk("R4 fast wrap", count, 16'h0);
        tick = 1; #1;
        chk("R8 bottom", {15'b0, bot_stb}, 16'h1);
        chk("R7 no ovf bottom fast", {15'b0, ovf_stb}, 16'h0);
        step();
        chk("R6 transfer at bottom", cmpa_act, 16'h40);
    endtask

    task automatic t_pc();
        do_reset(); mode = 4'd1;
        cmpa_we = 1; wr_data = 16'h20; step();
        chk("R6 buffered at top", cmpa_act, 16'h0);
        load_cnt(16'h00FE);
        tick_once();
        chk("R5 up to FF", count, 16'h00FF);
        tick = 1; #1;
        chk("R7 no ovf pc top", {15'b0, ovf_stb}, 16'h0);
        step();
        chk("R5 turn down", count, 16'h00FE);
        chk("R5 down flag", {15'b0, down}, 16'h1);
        chk("R6 transfer at top", cmpa_act, 16'h20);
        load_cnt(16'h0001);
        chk("R10 dir kept", {15'b0, down}, 16'h1);
        tick_once();
        chk("R5 reach 0", count, 16'h0);
        tick = 1; #1;
        chk("R7 ovf at bottom", {15'b0, ovf_stb}, 16'h1);
        step();
        chk("R5 turn up", count, 16'h1);
        chk("R5 up flag", {15'b0, down}, 16'h0);
    endtask

    task automatic t_pfc_cap();
        logic [15:0] exp [7] = '{16'd1, 16'd2, 16'd3, 16'd2, 16'd1, 16'd0, 16'd1};
        do_reset();
        cap_we = 1; wr_data = 16'd3; step();
        mode = 4'd8;
        for (int i = 0; i < 7; i++) begin
            tick = 1; #1;
            if (i == 6) chk("R7 ovf pfc bottom", {15'b0, ovf_stb}, 16'h1);
            step();
            chk("R11 R5 pfc seq", count, exp[i]);
        end
    endtask

    task automatic t_fast_src();
        logic [15:0] exp [4] = '{16'd1, 16'd2, 16'd0, 16'd1};
        do_reset();
        cap_we = 1; wr_data = 16'd2; step();
        mode = 4'd14;
        for (int i = 0; i < 4; i++) begin
            tick_once();
            chk("R3 cap top", count, exp[i]);
        end
        do_reset(); mode = 4'd4;
        cmpa_we = 1; wr_data = 16'd2; step();
        mode = 4'd15;
        for (int i = 0; i < 3; i++) begin
            tick_once();
            chk("R3 cmpa top", count, exp[i]);
        end
    endtask

    task automatic t_wide();
        do_reset(); mode = 4'd7;
        load_cnt(16'h03FF);
        tick = 1; #1;
        chk("R3 10-bit top", {15'b0, top_stb}, 16'h1);
        step();
        chk("R4 10-bit wrap", count, 16'h0);
        mode = 4'd3;
        load_cnt(16'h03FF);
        tick_once();
        chk("R5 10-bit pc", count, 16'h03FE);
    endtask

    task automatic t_reserved();
        do_reset(); mode = 4'd13;
        load_cnt(16'hFFFF);
        tick = 1; #1;
        chk("R4 reserved ovf", {15'b0, ovf_stb}, 16'h1);
        step();
        chk("R4 reserved wrap", count, 16'h0);
    endtask

    task automatic t_block();
        do_reset(); mode = 4'd0;
        cmpb_we = 1; wr_data = 16'd7; step();
        load_cnt(16'd7);
        tick = 1; #1;
        chk("R9 suppressed", {15'b0, cmpb_stb}, 16'h0);
        step();
        chk("R9 count 8", count, 16'd8);
        load_cnt(16'd6);
        tick_once();
        tick = 1; #1;
        chk("R9 match after", {15'b0, cmpb_stb}, 16'h1);
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_hold();
        t_normal();
        t_ctc();
        t_fast();
        t_pc();
        t_pfc_cap();
        t_fast_src();
        t_wide();
        t_reserved();
        t_block();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule